// File: doc/BRIEF.md
# Tearing-Effect Sync Trigger

This block watches one tearing-effect line from a display panel and turns the pulses on it into a start command for the pixel transfer engine. Horizontal and vertical sync share that one wire, so the block measures how long each pulse stays at its active level. A pulse that lasts at least the configured vertical width is taken as a frame sync. A pulse that lasts at least the horizontal width but less than the vertical width is taken as a line sync. Anything shorter is a glitch and is ignored.

Software arms the block with a one-cycle `arm_i` pulse. A 2-bit trigger mode then decides when the single-cycle `start_o` pulse goes out. In the internal mode it goes out at once. In frame mode it goes out on the next frame sync. In line mode it goes out when a line counter reaches the target line. The frame sync clears that counter and each line sync adds one to it. After one start the block waits for `frame_done_i` before it accepts another arm.

Top module: `te_sync_trigger`

## Requirements
- R1: With mode 0 (internal), an accepted `arm_i` in cycle n gives `start_o` high in cycle n+1 and low in cycle n+2, whatever `te_i` does.
- R2: With mode 1 (frame), `start_o` goes high for one cycle in the cycle right after the first cycle where `te_i` has left the active level, provided the pulse before it stayed active for at least `vs_width_i` cycles and the block was armed.
- R3: An active run of at least `hs_width_i` cycles but fewer than `vs_width_i` is a line sync and never a frame sync. A run shorter than `hs_width_i` is ignored completely and does not change the line count.
- R4: With mode 2 (line), a frame sync sets the line count to 0 and each line sync adds one, saturating at 2047. The trigger fires on the line sync that makes the count equal `line_i`. If `line_i` is 0, it fires on the frame sync.
- R5: Only one `start_o` pulse follows each accepted arm. Further `arm_i` pulses are ignored until `frame_done_i` has been seen after that start.
- R6: In modes 1 and 2, `arm_i` is ignored when the configuration is invalid. The configuration is invalid when `hs_width_i` is below 2, when `hs_width_i` equals `vs_width_i`, or when `vs_width_i` is below 4 in mode 1 or below 2 in mode 2.
- R7: Mode 3 is reserved. `arm_i` is ignored in mode 3, and an armed block produces no start while mode 3 is selected.
- R8: `vs_pol_i` and `hs_pol_i` set the active level of `te_i` for frame and line measurement: 1 means active-high, 0 means active-low.
- R9: During and after reset `start_o` is low and the block is unarmed. `start_o` is never high for two cycles in a row.
- R10: `line_i` is 11 bits wide, and the target value 2047 is reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| te_i | input | 1 | Tearing-effect line from the panel, already synchronous |
| arm_i | input | 1 | One-cycle request to arm the trigger |
| frame_done_i | input | 1 | Frame transfer finished; allows re-arming |
| mode_i | input | 2 | 0 internal, 1 frame sync, 2 line count, 3 reserved |
| hs_width_i | input | 6 | Minimum active length of a line sync, in cycles |
| vs_width_i | input | 6 | Minimum active length of a frame sync, in cycles |
| hs_pol_i | input | 1 | Active level for line-sync measurement |
| vs_pol_i | input | 1 | Active level for frame-sync measurement |
| line_i | input | 11 | Target line for mode 2 |
| start_o | output | 1 | One-cycle start pulse to the transfer engine |

## Verification
Some rules are checked on every cycle. These are: `start_o` is a single-cycle pulse, at most one start comes between two frame-done events, an internal-mode start always follows an arm, no start appears in the reserved mode, and a frame-mode start comes only right after `te_i` leaves a level. Other rules depend on how long pulses are, and only the directed scenarios can show them. These are the exact width thresholds between glitch, line sync and frame sync, line counting up to the target including 0 and 2047, rejection of invalid width settings, and active-low operation.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;
  typedef enum logic [1:0] {
    TRG_INT  = 2'd0,
    TRG_VS   = 2'd1,
    TRG_LINE = 2'd2,
    TRG_RSVD = 2'd3
  } trg_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BUSY  = 2'd2
  } arm_state_e;
endpackage

// File: rtl/te_run_meter.sv
module te_run_meter #(
  parameter int WW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          te_i,
  input  logic          pol_i,
  input  logic [WW-1:0] width_i,
  output logic          qual_o
);
  localparam logic [WW-1:0] RUN_MAX = '1;

  logic          act;
  logic [WW-1:0] run_q;

  assign act = (te_i == pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (!act)        run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
  end

  // run ended this cycle and lasted long enough
  assign qual_o = !act && (run_q != '0) && (run_q >= width_i);
endmodule

// File: rtl/te_line_counter.sv
module te_line_counter #(
  parameter int LW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vs_evt_i,
  input  logic          hs_evt_i,
  input  logic [LW-1:0] target_i,
  output logic          hit_o
);
  localparam logic [LW-1:0] CNT_MAX = '1;

  logic [LW-1:0] cnt_q, cnt_inc;

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (vs_evt_i) cnt_q <= '0;
    else if (hs_evt_i) cnt_q <= cnt_inc;
  end

  assign hit_o = (vs_evt_i && target_i == '0) ||
                 (hs_evt_i && cnt_inc == target_i && target_i != '0);
endmodule

// File: rtl/te_arm_ctrl.sv
module te_arm_ctrl
  import te_sync_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       done_i,
  input  trg_mode_e  mode_i,
  input  logic       cfg_ok_i,
  input  logic       vs_evt_i,
  input  logic       line_hit_i,
  output logic       start_o
);
  arm_state_e st_q, st_d;
  logic       start_d, accept, fire;

  assign accept = arm_i && ((mode_i == TRG_INT) ||
                  ((mode_i == TRG_VS || mode_i == TRG_LINE) && cfg_ok_i));
  assign fire   = cfg_ok_i && ((mode_i == TRG_VS && vs_evt_i) ||
                               (mode_i == TRG_LINE && line_hit_i));

  always_comb begin
    st_d    = st_q;
    start_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        if (mode_i == TRG_INT) begin
          st_d    = ST_BUSY;
          start_d = 1'b1;
        end else begin
          st_d = ST_ARMED;
        end
      end
      ST_ARMED: if (fire) begin
        st_d    = ST_BUSY;
        start_d = 1'b1;
      end
      ST_BUSY:  if (done_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      start_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_o <= start_d;
    end
  end
endmodule

// File: rtl/te_sync_trigger.sv
module te_sync_trigger
  import te_sync_pkg::*;
#(
  parameter int WW        = 6,
  parameter int LW        = 11,
  parameter int HS_MIN    = 2,
  parameter int VS_MIN_M1 = 4,
  parameter int VS_MIN_M2 = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          te_i,
  input  logic          arm_i,
  input  logic          frame_done_i,
  input  logic [1:0]    mode_i,
  input  logic [WW-1:0] hs_width_i,
  input  logic [WW-1:0] vs_width_i,
  input  logic          hs_pol_i,
  input  logic          vs_pol_i,
  input  logic [LW-1:0] line_i,
  output logic          start_o
);
  localparam logic [WW-1:0] HS_LIM  = WW'(HS_MIN);
  localparam logic [WW-1:0] VS_LIM1 = WW'(VS_MIN_M1);
  localparam logic [WW-1:0] VS_LIM2 = WW'(VS_MIN_M2);

  trg_mode_e mode;
  logic      vs_qual, hs_qual, vs_evt, hs_evt, line_hit, cfg_ok;
  logic [WW-1:0] vs_lim;

  assign mode   = trg_mode_e'(mode_i);
  assign vs_lim = (mode == TRG_VS) ? VS_LIM1 : VS_LIM2;
  assign cfg_ok = (hs_width_i >= HS_LIM) && (vs_width_i >= vs_lim) &&
                  (hs_width_i != vs_width_i);

  te_run_meter #(.WW(WW)) u_vs_meter (
    .clk_i, .rst_ni, .te_i, .pol_i(vs_pol_i), .width_i(vs_width_i), .qual_o(vs_qual)
  );
  te_run_meter #(.WW(WW)) u_hs_meter (
    .clk_i, .rst_ni, .te_i, .pol_i(hs_pol_i), .width_i(hs_width_i), .qual_o(hs_qual)
  );

  // frame sync wins when both qualify
  assign vs_evt = vs_qual;
  assign hs_evt = hs_qual && !vs_qual;

  te_line_counter #(.LW(LW)) u_line (
    .clk_i, .rst_ni, .vs_evt_i(vs_evt), .hs_evt_i(hs_evt),
    .target_i(line_i), .hit_o(line_hit)
  );

  te_arm_ctrl u_ctrl (
    .clk_i, .rst_ni, .arm_i, .done_i(frame_done_i), .mode_i(mode),
    .cfg_ok_i(cfg_ok), .vs_evt_i(vs_evt), .line_hit_i(line_hit), .start_o
  );
endmodule

// File: rtl/te_sync_trigger_chk.sv
module te_sync_trigger_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       te_i,
  input logic       arm_i,
  input logic       frame_done_i,
  input logic [1:0] mode_i,
  input logic       vs_pol_i,
  input logic       start_o
);
  logic pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pending_q <= 1'b0;
    else if (start_o)      pending_q <= 1'b1;
    else if (frame_done_i) pending_q <= 1'b0;
  end

  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R9

  AST_ONE_PER_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !pending_q); // R5

  AST_INT_AFTER_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && $past(mode_i) == 2'd0) |-> $past(arm_i)); // R1

  AST_RSVD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(mode_i) != 2'd3); // R7

  AST_VS_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && $past(mode_i) == 2'd1 && $past(vs_pol_i) == $past(vs_pol_i, 2))
      |-> $past(te_i) != $past(te_i, 2)); // R2
endmodule

bind te_sync_trigger te_sync_trigger_chk u_chk (
  .clk_i, .rst_ni, .te_i, .arm_i, .frame_done_i, .mode_i, .vs_pol_i, .start_o
);

// File: tb/te_sync_trigger_tb.sv
`timescale 1ns/1ps
module te_sync_trigger_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        te = 1'b0, arm = 1'b0, fdone = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [5:0]  hs_w = 6'd2, vs_w = 6'd5;
  logic        hs_pol = 1'b1, vs_pol = 1'b1;
  logic [10:0] line = 11'd0;
  logic        start;

  int checks = 0, errors = 0, start_cnt = 0;

  always #4 clk = ~clk;

  te_sync_trigger u_dut (
    .clk_i(clk), .rst_ni(rst_n), .te_i(te), .arm_i(arm), .frame_done_i(fdone),
    .mode_i(mode), .hs_width_i(hs_w), .vs_width_i(vs_w), .hs_pol_i(hs_pol),
    .vs_pol_i(vs_pol), .line_i(line), .start_o(start)
  );

  always @(negedge clk) if (start) start_cnt++;

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic te_pulse(input int n, input int gap);
    te = vs_pol;
    repeat (n) @(negedge clk);
    te = ~vs_pol;
    repeat (gap) @(negedge clk);
    #1;
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    #1;
  endtask

  task automatic do_done();
    @(negedge clk); fdone = 1'b1;
    @(negedge clk); fdone = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    start_cnt = 0;
  endtask

  task automatic t_reset();
    te = ~vs_pol;
    repeat (3) @(negedge clk);
    chk(start, 0, "R9 start low in reset");
    rst_n = 1'b1;
    repeat (3) settle();
    chk(start_cnt, 0, "R9 no start after reset");
  endtask

  task automatic t_mode0();
    mode = 2'd0;
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0; #1;
    chk(start, 1, "R1 start cycle after arm");
    settle();
    chk(start, 0, "R1 start single cycle");
    do_done();
  endtask

  task automatic t_mode1();
    mode = 2'd1; hs_w = 6'd2; vs_w = 6'd5;
    do_arm();
    te_pulse(4, 3);
    chk(start_cnt, 0, "R3 width below vs is line sync");
    te = vs_pol;
    repeat (5) @(negedge clk);
    te = ~vs_pol;
    @(negedge clk); #1;
    chk(start, 1, "R2 start right after frame pulse ends");
    settle();
    chk(start, 0, "R2 start single cycle");
    repeat (2) settle();
    chk(start_cnt, 1, "R2 one start");
    do_done();
  endtask

  task automatic t_rearm();
    mode = 2'd1;
    do_arm();
    te_pulse(6, 3);
    chk(start_cnt, 1, "R5 first start");
    te_pulse(6, 3);
    chk(start_cnt, 1, "R5 no second start on vsync");
    do_arm();
    te_pulse(6, 3);
    chk(start_cnt, 1, "R5 arm before frame done ignored");
    do_done();
    do_arm();
    te_pulse(6, 3);
    chk(start_cnt, 1, "R5 rearm after frame done");
    do_done();
  endtask

  task automatic t_mode2();
    mode = 2'd2; hs_w = 6'd2; vs_w = 6'd5; line = 11'd3;
    do_arm();
    te_pulse(6, 2);
    te_pulse(3, 2);
    te_pulse(1, 2);
    te_pulse(2, 2);
    chk(start_cnt, 0, "R3 glitch not counted");
    te_pulse(3, 3);
    chk(start_cnt, 1, "R4 fire at target line");
    do_done();
    line = 11'd0;
    do_arm();
    te_pulse(2, 2);
    chk(start_cnt, 0, "R4 line sync does not hit target 0");
    te_pulse(5, 3);
    chk(start_cnt, 1, "R4 target 0 fires on frame sync");
    do_done();
  endtask

  task automatic t_cfg();
    mode = 2'd1; hs_w = 6'd4; vs_w = 6'd4;
    do_arm(); te_pulse(8, 3);
    chk(start_cnt, 0, "R6 equal widths rejected");
    hs_w = 6'd1; vs_w = 6'd5;
    do_arm(); te_pulse(8, 3);
    chk(start_cnt, 0, "R6 hs width below 2 rejected");
    hs_w = 6'd2; vs_w = 6'd3;
    do_arm(); te_pulse(8, 3);
    chk(start_cnt, 0, "R6 vs width below 4 rejected in mode 1");
    mode = 2'd2; line = 11'd0;
    do_arm(); te_pulse(3, 3);
    chk(start_cnt, 1, "R6 vs width 3 accepted in mode 2");
    do_done();
  endtask

  task automatic t_rsvd();
    mode = 2'd3; hs_w = 6'd2; vs_w = 6'd5;
    do_arm(); te_pulse(8, 3);
    chk(start_cnt, 0, "R7 reserved mode ignores arm");
    mode = 2'd1;
    te_pulse(8, 3);
    chk(start_cnt, 0, "R7 arm in reserved mode not kept");
  endtask

  task automatic t_polarity();
    mode = 2'd1; vs_pol = 1'b0; hs_pol = 1'b0;
    te = 1'b1;
    repeat (3) settle();
    do_arm();
    repeat (10) settle();
    chk(start_cnt, 0, "R8 inactive-high level gives no start");
    te_pulse(6, 3);
    chk(start_cnt, 1, "R8 active-low frame sync fires");
    do_done();
    vs_pol = 1'b1; hs_pol = 1'b1; te = 1'b0;
    repeat (3) settle();
  endtask

  task automatic t_line_max();
    mode = 2'd2; hs_w = 6'd2; vs_w = 6'd4; line = 11'd2047;
    do_arm();
    te_pulse(4, 1);
    for (int i = 0; i < 2046; i++) te_pulse(2, 1);
    repeat (2) settle();
    chk(start_cnt, 0, "R10 no start before line 2047");
    te_pulse(2, 3);
    chk(start_cnt, 1, "R10 start at line 2047");
    do_done();
  endtask

  initial begin
    t_reset();
    t_mode0();
    t_mode1();
    t_rearm();
    t_mode2();
    t_cfg();
    t_rsvd();
    t_polarity();
    t_line_max();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule